// File: doc/BRIEF.md
# Registered Carry-Select Adder-Subtractor

This block adds or subtracts two unsigned/two's-complement operands of a parameterised width and registers the result. The operand is cut into sections of a fixed number of bits (five by default). Inside a section every bit slice works out its sum and carry twice, in parallel: once as if the section's incoming carry were 0 and once as if it were 1. The real carry reaching a section then only picks one of the two ready-made answers. As a result, the long path runs only from one section boundary to the next. The last section may be narrower than the others and is built the same way.

A run-time control picks addition or subtraction. For subtraction, operand B is inverted and the control drives the carry into the lowest bit, so the operation is A + ~B + 1. The result is held in a register that has an asynchronous clear, a synchronous clear, a synchronous load of an outside value and a clock enable. The register also holds the final carry and a signed-overflow flag.

Top module: `csel_addsub_reg`

## Requirements
- R1: With `sub_mode`=0, `hold_en`=1, `sync_clr`=0 and `sync_load`=0, the clock edge stores (A+B) mod 2^WIDTH in `res_q` and bit WIDTH of the unsigned sum in `carry_q`.
- R2: With `sub_mode`=1 and the same controls as R1, the edge stores (A−B) mod 2^WIDTH in `res_q`. `carry_q` gets the carry out of A + ~B + 1, which is 1 exactly when A ≥ B as unsigned values.
- R3: On an arithmetic capture, `ovf_q` is 1 exactly when the two's-complement result of A+B (or A−B) falls outside the signed range of WIDTH bits.
- R4: While `arst_n` is 0, `res_q`, `carry_q` and `ovf_q` are all 0 at once, without waiting for a clock edge.
- R5: `sync_clr`=1 zeroes all three outputs at the clock edge. It overrides `sync_load` and `hold_en`.
- R6: `sync_load`=1 with `sync_clr`=0 stores `load_val` in `res_q` and zeroes `carry_q` and `ovf_q` at the edge, whatever the value of `hold_en`.
- R7: With `hold_en`=0, `sync_clr`=0 and `sync_load`=0, all outputs keep their values across the edge.
- R8: The result is correct when carries ripple across every section boundary, including the narrower last section (for example all ones plus one, or all ones plus all ones).
- R9: Every result appears on the outputs at the first rising edge after its inputs are applied, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous clear, active low |
| hold_en | input | 1 | Clock enable for the arithmetic capture |
| sync_clr | input | 1 | Synchronous clear, highest synchronous priority |
| sync_load | input | 1 | Synchronous load of `load_val` |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| load_val | input | WIDTH | Value stored by a synchronous load |
| res_q | output | WIDTH | Registered result |
| carry_q | output | 1 | Registered final carry |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
The bench goes after carries that must cross every five-bit boundary and the short last section: all ones plus one, all ones plus all ones, and patterns that end exactly at bits 4, 9 and 14. A design that picks the wrong precomputed chain gets a result off by a power of two at one section. Subtraction corners include zero minus one, equal operands, and largest positive minus most negative. A design that puts the subtract control into every section, or inverts the carry sense, gets the borrow or the overflow flag wrong there. Control priority is driven with clear, load and enable set at the same time, and an asynchronous clear lands between edges. A design with the priority order swapped, or with the clear made synchronous, shows stale values.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef struct packed {
    logic s;
    logic c;
  } fa_t;

  // One-bit full add: sum and carry-out.
  function automatic fa_t full_add(input logic a, input logic b, input logic c);
    fa_t r;
    r.s = a ^ b ^ c;
    r.c = (a & b) | (c & (a ^ b));
    return r;
  endfunction

  // Number of sections needed to cover a width.
  function automatic int sec_count(input int width, input int sec_bits);
    return (width + sec_bits - 1) / sec_bits;
  endfunction

  // Width of section idx; the last one takes the remainder.
  function automatic int sec_width(input int width, input int sec_bits, input int idx);
    int n;
    n = sec_count(width, sec_bits);
    if (idx < n - 1) return sec_bits;
    return width - (n - 1) * sec_bits;
  endfunction

  // Carry into a bit, recovered from its operands and sum.
  function automatic logic carry_in_of(input logic a, input logic b, input logic s);
    return a ^ b ^ s;
  endfunction

endpackage

// File: rtl/csa_dual_slice.sv
module csa_dual_slice
  import csa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci_if0,
  input  logic ci_if1,
  output logic s_if0,
  output logic s_if1,
  output logic co_if0,
  output logic co_if1
);

  fa_t path0;
  fa_t path1;

  // Both assumed chains are evaluated side by side.
  always_comb begin
    path0  = full_add(a, b, ci_if0);
    path1  = full_add(a, b, ci_if1);
    s_if0  = path0.s;
    co_if0 = path0.c;
    s_if1  = path1.s;
    co_if1 = path1.c;
  end

endmodule

// File: rtl/csa_section.sv
module csa_section #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0]   chain0;
  logic [WIDTH:0]   chain1;
  logic [WIDTH-1:0] sum0;
  logic [WIDTH-1:0] sum1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    csa_dual_slice u_slice (
      .a      (a[i]),
      .b      (b[i]),
      .ci_if0 (chain0[i]),
      .ci_if1 (chain1[i]),
      .s_if0  (sum0[i]),
      .s_if1  (sum1[i]),
      .co_if0 (chain0[i+1]),
      .co_if1 (chain1[i+1])
    );
  end

  // The true carry only selects here.
  assign sum  = cin ? sum1 : sum0;
  assign cout = cin ? chain1[WIDTH] : chain0[WIDTH];

endmodule

// File: rtl/csa_result_reg.sv
module csa_result_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hold_en,
  input  logic             sync_clr,
  input  logic             sync_load,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_carry,
  input  logic             d_ovf,
  output logic [WIDTH-1:0] q_res,
  output logic             q_carry,
  output logic             q_ovf
);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q_res   <= '0;
      q_carry <= 1'b0;
      q_ovf   <= 1'b0;
    end else if (sync_clr) begin
      q_res   <= '0;
      q_carry <= 1'b0;
      q_ovf   <= 1'b0;
    end else if (sync_load) begin
      q_res   <= load_val;
      q_carry <= 1'b0;
      q_ovf   <= 1'b0;
    end else if (hold_en) begin
      q_res   <= d_res;
      q_carry <= d_carry;
      q_ovf   <= d_ovf;
    end
  end

endmodule

// File: rtl/csel_addsub_reg.sv
module csel_addsub_reg
  import csa_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int SEC_BITS = 5
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hold_en,
  input  logic             sync_clr,
  input  logic             sync_load,
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] res_q,
  output logic             carry_q,
  output logic             ovf_q
);

  localparam int NSEC = sec_count(WIDTH, SEC_BITS);
  localparam int MSB  = WIDTH - 1;

  // Named internal events, visible to the checker.
  logic [WIDTH-1:0] b_eff;
  logic [NSEC:0]    sec_carry;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_cout;
  logic             carry_into_msb;
  logic             arith_ovf;

  assign b_eff        = op_b ^ {WIDTH{sub_mode}};
  // The mode control enters only at the very first carry input.
  assign sec_carry[0] = sub_mode;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    localparam int LO = g * SEC_BITS;
    localparam int SW = sec_width(WIDTH, SEC_BITS, g);
    csa_section #(.WIDTH(SW)) u_sec (
      .a    (op_a[LO +: SW]),
      .b    (b_eff[LO +: SW]),
      .cin  (sec_carry[g]),
      .sum  (arith_sum[LO +: SW]),
      .cout (sec_carry[g+1])
    );
  end

  assign arith_cout     = sec_carry[NSEC];
  assign carry_into_msb = carry_in_of(op_a[MSB], b_eff[MSB], arith_sum[MSB]);
  assign arith_ovf      = carry_into_msb ^ arith_cout;

  csa_result_reg #(.WIDTH(WIDTH)) u_reg (
    .clk       (clk),
    .arst_n    (arst_n),
    .hold_en   (hold_en),
    .sync_clr  (sync_clr),
    .sync_load (sync_load),
    .load_val  (load_val),
    .d_res     (arith_sum),
    .d_carry   (arith_cout),
    .d_ovf     (arith_ovf),
    .q_res     (res_q),
    .q_carry   (carry_q),
    .q_ovf     (ovf_q)
  );

endmodule

// File: rtl/csa_addsub_chk.sv
module csa_addsub_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             arst_n,
  input logic             hold_en,
  input logic             sync_clr,
  input logic             sync_load,
  input logic             sub_mode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] arith_sum,
  input logic [WIDTH-1:0] res_q,
  input logic             carry_q,
  input logic             ovf_q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   add_full;
  logic [WIDTH-1:0] sub_res;
  logic [WIDTH-1:0] ref_res;
  logic             ref_ovf;
  logic             capture;

  assign add_full = {1'b0, op_a} + {1'b0, op_b};
  assign sub_res  = op_a - op_b;
  assign ref_res  = sub_mode ? sub_res : add_full[WIDTH-1:0];
  // Sign rule: operands of matching effective sign, result sign differs.
  assign ref_ovf  = sub_mode ?
                    ((op_a[MSB] != op_b[MSB]) && (sub_res[MSB] != op_a[MSB])) :
                    ((op_a[MSB] == op_b[MSB]) && (add_full[MSB] != op_a[MSB]));
  assign capture  = hold_en && !sync_clr && !sync_load;

  a_r1_add: assert property (@(posedge clk) disable iff (!arst_n)
    (capture && !sub_mode) |=> ({carry_q, res_q} == $past(add_full)));

  a_r2_sub: assert property (@(posedge clk) disable iff (!arst_n)
    (capture && sub_mode) |=> (res_q == $past(sub_res)) && (carry_q == $past(op_a >= op_b)));

  a_r3_overflow: assert property (@(posedge clk) disable iff (!arst_n)
    capture |=> (ovf_q == $past(ref_ovf)));

  always @(posedge clk) begin
    if (!arst_n) begin
      a_r4_async_clear: assert (res_q == '0 && !carry_q && !ovf_q);
    end
  end

  a_r5_sync_clear: assert property (@(posedge clk) disable iff (!arst_n)
    sync_clr |=> (res_q == '0) && !carry_q && !ovf_q);

  a_r6_sync_load: assert property (@(posedge clk) disable iff (!arst_n)
    (sync_load && !sync_clr) |=> (res_q == $past(load_val)) && !carry_q && !ovf_q);

  a_r7_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (!hold_en && !sync_clr && !sync_load) |=> $stable(res_q) && $stable(carry_q) && $stable(ovf_q));

  a_r8_sections: assert property (@(posedge clk) disable iff (!arst_n)
    arith_sum == ref_res);

endmodule

bind csel_addsub_reg csa_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .hold_en   (hold_en),
  .sync_clr  (sync_clr),
  .sync_load (sync_load),
  .sub_mode  (sub_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .load_val  (load_val),
  .arith_sum (arith_sum),
  .res_q     (res_q),
  .carry_q   (carry_q),
  .ovf_q     (ovf_q)
);

// File: tb/csel_addsub_reg_tb.sv
module csel_addsub_reg_tb;

  localparam int W = 16;
  localparam longint MOD  = longint'(1) << W;
  localparam longint SMAX = (longint'(1) << (W - 1)) - 1;
  localparam longint SMIN = -(longint'(1) << (W - 1));

  logic         clk = 1'b0;
  logic         arst_n = 1'b1;
  logic         hold_en = 1'b0, sync_clr = 1'b0, sync_load = 1'b0, sub_mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, load_val = '0;
  logic [W-1:0] res_q;
  logic         carry_q, ovf_q;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state.
  longint e_res = 0;
  bit     e_carry = 0;
  bit     e_ovf = 0;

  always #4 clk = ~clk;

  csel_addsub_reg #(.WIDTH(W), .SEC_BITS(5)) u_dut (
    .clk(clk), .arst_n(arst_n), .hold_en(hold_en), .sync_clr(sync_clr),
    .sync_load(sync_load), .sub_mode(sub_mode), .op_a(op_a), .op_b(op_b),
    .load_val(load_val), .res_q(res_q), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  function automatic longint to_signed(input longint u);
    return (u > SMAX) ? u - MOD : u;
  endfunction

  task automatic compare(input string tag);
    tests++;
    if (longint'(res_q) != e_res || carry_q != e_carry) begin
      fails++;
      $display("FAIL %s result: actual res=%h carry=%0d expected res=%h carry=%0d",
               tag, res_q, carry_q, e_res[W-1:0], e_carry);
    end
    tests++;
    if (ovf_q != e_ovf) begin
      fails++;
      $display("FAIL %s/R3 overflow: actual=%0d expected=%0d", tag, ovf_q, e_ovf);
    end
  endtask

  // One clock: drive at the falling edge, model the rising edge, check after it (R9).
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic sb,
                      input logic en, input logic clr, input logic ld,
                      input logic [W-1:0] lv, input string note);
    longint ua, ub, sr;
    string  tag;
    @(negedge clk);
    op_a = a; op_b = b; sub_mode = sb; hold_en = en;
    sync_clr = clr; sync_load = ld; load_val = lv;
    @(posedge clk);
    ua = longint'(a);
    ub = longint'(b);
    if (clr) begin
      tag = "R5"; e_res = 0; e_carry = 0; e_ovf = 0;
    end else if (ld) begin
      tag = "R6"; e_res = longint'(lv); e_carry = 0; e_ovf = 0;
    end else if (!en) begin
      tag = "R7";
    end else if (!sb) begin
      tag = "R1";
      e_res   = (ua + ub) % MOD;
      e_carry = (ua + ub) >= MOD;
      sr      = to_signed(ua) + to_signed(ub);
      e_ovf   = (sr > SMAX) || (sr < SMIN);
    end else begin
      tag = "R2";
      e_res   = (ua - ub + MOD) % MOD;
      e_carry = (ua >= ub);
      sr      = to_signed(ua) - to_signed(ub);
      e_ovf   = (sr > SMAX) || (sr < SMIN);
    end
    #2;
    compare({tag, " ", note});
  endtask

  task automatic arith(input logic [W-1:0] a, input logic [W-1:0] b, input logic sb,
                       input string note);
    step(a, b, sb, 1'b1, 1'b0, 1'b0, '0, note);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1 arst_n = 1'b0;
    #2;
    compare("R4 reset state");
    repeat (2) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;

    // Adds and section-boundary ripples (R1, R8).
    arith(16'h0000, 16'h0000, 1'b0, "zero+zero");
    arith(16'hFFFF, 16'h0001, 1'b0, "R8 all-ones+1");
    arith(16'hFFFF, 16'hFFFF, 1'b0, "R8 all-ones+all-ones");
    arith(16'h001F, 16'h0001, 1'b0, "R8 cross bit4");
    arith(16'h03FF, 16'h0001, 1'b0, "R8 cross bit9");
    arith(16'h7FFF, 16'h0001, 1'b0, "R8 cross bit14, overflow");
    arith(16'h8000, 16'h8000, 1'b0, "neg+neg overflow");
    arith(16'hAAAA, 16'h5555, 1'b0, "alternating");
    // Subtractions (R2, R3).
    arith(16'h0000, 16'h0001, 1'b1, "zero-one borrow");
    arith(16'h1234, 16'h1234, 1'b1, "equal operands");
    arith(16'h7FFF, 16'h8000, 1'b1, "maxpos-minneg");
    arith(16'h8000, 16'h0001, 1'b1, "minneg-one");
    arith(16'hFFFF, 16'h0000, 1'b1, "all-ones-zero");

    // Control priority (R5, R6, R7).
    step(16'h1111, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF, "load with enable low");
    step(16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "hold ignores operands");
    step(16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234, "clear beats load and enable");
    arith(16'hFFFF, 16'hFFFF, 1'b0, "set carry before hold");
    step(16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, "hold keeps carry");
    step(16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00A5, "load beats enable");

    // Asynchronous clear between edges (R4).
    arith(16'h4000, 16'h4000, 1'b0, "nonzero before async clear");
    @(negedge clk);
    #1 arst_n = 1'b0;
    #1;
    e_res = 0; e_carry = 0; e_ovf = 0;
    compare("R4 async clear mid-cycle");
    @(negedge clk);
    arst_n = 1'b1;

    // Random traffic across all modes.
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb, rl;
      int unsigned  sel;
      ra  = W'($urandom);
      rb  = W'($urandom);
      rl  = W'($urandom);
      sel = $urandom % 16;
      step(ra, rb, sel[0], sel != 1, sel == 2, sel == 3 || sel == 2, rl, "random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule